// File: doc/BRIEF.md
# Clock Output Stop and Power-Down Sequencer

This block decides, edge by edge, what each of a set of differential clock output pairs shows: a running clock, a parked level, or nothing driven. It runs on a clock at twice the output rate. An internal phase bit toggles on every edge and forms the output clock, so every edge of `clk` is one output transition. The bench counts edges from the first edge after reset release. After edge n the running true leg equals n mod 2, and the complement leg is its inverse.

Two asynchronous requests are accepted only after a debounce. The first is a stop request, which halts the pairs marked stoppable. The second is a power-down request, which parks every pair. Each request is synchronised and then qualified on the edges where the complement leg rises, which are the even edges. How a stopped or powered-down pair rests depends on two drive-mode bits. In one mode the true leg is held driven high. In the other mode both legs are released. A leg that is not driven always reads low. Outputs that were stopped all resume together, on a rising true edge, a fixed number of periods after the stop is withdrawn. A per-pair enable bit is combined with a per-pair enable pin. The active level of the pin is set by a strap that is captured during reset.

Top module: `clkout_stop_seq`

## Requirements
- R1: While `rst` is high, every output is 0. The `oe_strap_i` level is captured only while `rst` is high, so changing it later has no effect.
- R2: A request input is synchronised through two flops. It is then sampled on the even edges. A new level is accepted on the second consecutive even-edge sample that shows it. If a level change is presented after edge k, it is accepted at edge q = k+5 when k is odd and q = k+6 when k is even.
- R3: When a stop is accepted at edge q, a pair with its `ctl_stoppable_i` bit at 1 parks after its next transition. A pair with the bit at 0 keeps running.
- R4: With `ctl_stop_tri_i`=0, a stopped pair parks at edge q+1 with true=1 driven and the complement undriven. With `ctl_stop_tri_i`=1, it parks at edge q+2 with both legs undriven. An undriven leg reads 0.
- R5: When a stop deassertion is accepted at edge q, every stopped pair resumes at edge q+7, with the true leg high and in phase with the free-running pairs. Up to edge q+6 the pairs stay parked.
- R6: When a power-down is accepted at edge q, every enabled pair parks at edge q+1, on the complement's falling edge. With `ctl_pd_tri_i`=0 the true leg is driven high and the complement is undriven. With `ctl_pd_tri_i`=1 both legs are undriven. When a power-down deassertion is accepted at edge q, running resumes at edge q+1.
- R7: A power-down overrides a stop. After power-down releases, a pair that is still stopped shows its stop parking until its restart.
- R8: With `ctl_req_inv_i`=0 both request inputs are active-low. With `ctl_req_inv_i`=1 both are active-high.
- R9: A pair is enabled when `ctl_oe_i` is 1 and `oe_pin_i` is at its active level. The active level is 1 when the captured strap is 0, and 0 when the strap is 1. A disabled pair has both legs undriven one edge later, whatever the stop or power-down state.
- R10: A request active for a single cycle is never accepted, and the outputs keep running.
- R11: A pair running with both legs driven toggles on every edge, with complementary legs. All running pairs are in phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the output rate |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_i | input | 1 | Asynchronous stop request, polarity set by `ctl_req_inv_i` |
| pd_req_i | input | 1 | Asynchronous power-down request, polarity set by `ctl_req_inv_i` |
| oe_strap_i | input | 1 | Enable-pin polarity strap, captured during reset (1 = pins active-low) |
| oe_pin_i | input | N_PAIRS | Per-pair enable pins |
| ctl_oe_i | input | N_PAIRS | Per-pair enable control bits |
| ctl_stoppable_i | input | N_PAIRS | 1 = pair obeys stop, 0 = free-running |
| ctl_stop_tri_i | input | 1 | Stop parking mode (0 = true leg driven high, 1 = both undriven) |
| ctl_pd_tri_i | input | 1 | Power-down parking mode (0 = true leg driven high, 1 = both undriven) |
| ctl_req_inv_i | input | 1 | 1 makes both requests active-high |
| dif_t_o | output | N_PAIRS | True leg levels |
| dif_c_o | output | N_PAIRS | Complement leg levels |
| dif_t_en_o | output | N_PAIRS | True leg drive enables |
| dif_c_en_o | output | N_PAIRS | Complement leg drive enables |

## Verification
The stop is tested in both parking modes. The request is presented after both odd and even edges, so the exact-edge checks can tell the k+5 and k+6 acceptance cases apart. They can also tell an early or late park from a correct one. Power-down is tested in both modes, and in a case where it is raised and dropped together with a stop. That case shows whether power-down has priority, and whether the stop parking shows through before the restart. A one-cycle request pulse, inverted request polarity, an enable strap at each level, and a cleared enable bit complete the patterns. Each one separates the filter, the polarity logic and the enable logic from the sequencing.

// File: rtl/clkout_stop_seq_pkg.sv
package clkout_stop_seq_pkg;

  typedef enum logic [2:0] {
    LEG_RUN,
    LEG_STOP_DRV,
    LEG_STOP_TRI,
    LEG_PD_DRV,
    LEG_PD_TRI,
    LEG_OFF
  } leg_mode_e;

  typedef struct packed {
    logic t;
    logic c;
    logic t_en;
    logic c_en;
  } pair_drive_t;

  function automatic pair_drive_t drive_for(leg_mode_e mode, logic ph);
    pair_drive_t d;
    d = '0;
    case (mode)
      LEG_RUN: begin
        d.t    = ph;
        d.c    = ~ph;
        d.t_en = 1'b1;
        d.c_en = 1'b1;
      end
      LEG_STOP_DRV, LEG_PD_DRV: begin
        d.t    = 1'b1;
        d.t_en = 1'b1;
      end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/ckseq_req_filter.sv
module ckseq_req_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic inv_i,
  input  logic tick_i,
  output logic acc_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         level;
  logic         prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {SYNC_STAGES{~inv_i}};
    else     sync_q <= {sync_q[MSB-1:0], raw_i};
  end

  assign level = inv_i ? sync_q[MSB] : ~sync_q[MSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      acc_o  <= 1'b0;
    end else if (tick_i) begin
      prev_q <= level;
      if (prev_q == level) acc_o <= level;
    end
  end
endmodule

// File: rtl/ckseq_restart_timer.sv
module ckseq_restart_timer #(
  parameter int PERIODS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_acc_i,
  input  logic tick_i,
  input  logic rise_next_i,
  output logic release_o
);
  localparam int CW = $clog2(PERIODS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || stop_acc_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != CW'(PERIODS)) cnt_q <= cnt_q + 1'b1;
  end

  assign release_o = !stop_acc_i && (cnt_q == CW'(PERIODS)) && rise_next_i;
endmodule

// File: rtl/ckseq_pair.sv
module ckseq_pair
  import clkout_stop_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        next_phase_i,
  input  logic        enable_i,
  input  logic        stoppable_i,
  input  logic        stop_acc_i,
  input  logic        release_i,
  input  logic        pd_park_i,
  input  logic        stop_tri_i,
  input  logic        pd_tri_i,
  output pair_drive_t drv_o
);
  logic      stopped_q;
  logic      stopped_d;
  logic      park_lvl;
  leg_mode_e mode;

  assign park_lvl = ~stop_tri_i;

  always_comb begin
    if (stopped_q) stopped_d = ~release_i;
    else           stopped_d = stop_acc_i & stoppable_i & (next_phase_i == park_lvl);
  end

  always_comb begin
    if (!enable_i)      mode = LEG_OFF;
    else if (pd_park_i) mode = pd_tri_i ? LEG_PD_TRI : LEG_PD_DRV;
    else if (stopped_d) mode = stop_tri_i ? LEG_STOP_TRI : LEG_STOP_DRV;
    else                mode = LEG_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stopped_q <= 1'b0;
      drv_o     <= '0;
    end else begin
      stopped_q <= stopped_d;
      drv_o     <= drive_for(mode, next_phase_i);
    end
  end
endmodule

// File: rtl/clkout_stop_seq.sv
module clkout_stop_seq
  import clkout_stop_seq_pkg::*;
#(
  parameter int N_PAIRS         = 4,
  parameter int SYNC_STAGES     = 2,
  parameter int RESTART_PERIODS = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stop_req_i,
  input  logic               pd_req_i,
  input  logic               oe_strap_i,
  input  logic [N_PAIRS-1:0] oe_pin_i,
  input  logic [N_PAIRS-1:0] ctl_oe_i,
  input  logic [N_PAIRS-1:0] ctl_stoppable_i,
  input  logic               ctl_stop_tri_i,
  input  logic               ctl_pd_tri_i,
  input  logic               ctl_req_inv_i,
  output logic [N_PAIRS-1:0] dif_t_o,
  output logic [N_PAIRS-1:0] dif_c_o,
  output logic [N_PAIRS-1:0] dif_t_en_o,
  output logic [N_PAIRS-1:0] dif_c_en_o
);
  logic               phase_q;
  logic               tick;
  logic               rise_next;
  logic               pol_q;
  logic               stop_acc;
  logic               pd_acc;
  logic               pd_park_q;
  logic               pd_park_d;
  logic               restart;
  logic [N_PAIRS-1:0] pin_on;
  logic [N_PAIRS-1:0] pair_en;

  // complement leg rises when the phase leaves 1
  assign tick      = phase_q;
  assign rise_next = ~phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= ~phase_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pol_q <= oe_strap_i;
  end

  assign pin_on  = pol_q ? ~oe_pin_i : oe_pin_i;
  assign pair_en = ctl_oe_i & pin_on;

  ckseq_req_filter #(.SYNC_STAGES(SYNC_STAGES)) u_stop_filt (
    .clk(clk), .rst(rst), .raw_i(stop_req_i), .inv_i(ctl_req_inv_i),
    .tick_i(tick), .acc_o(stop_acc)
  );

  ckseq_req_filter #(.SYNC_STAGES(SYNC_STAGES)) u_pd_filt (
    .clk(clk), .rst(rst), .raw_i(pd_req_i), .inv_i(ctl_req_inv_i),
    .tick_i(tick), .acc_o(pd_acc)
  );

  // power-down parks and releases on the complement's falling edge
  assign pd_park_d = rise_next ? pd_acc : pd_park_q;

  always_ff @(posedge clk) begin
    if (rst) pd_park_q <= 1'b0;
    else     pd_park_q <= pd_park_d;
  end

  ckseq_restart_timer #(.PERIODS(RESTART_PERIODS)) u_restart (
    .clk(clk), .rst(rst), .stop_acc_i(stop_acc), .tick_i(tick),
    .rise_next_i(rise_next), .release_o(restart)
  );

  for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
    pair_drive_t drv;

    ckseq_pair u_pair (
      .clk(clk), .rst(rst), .next_phase_i(~phase_q), .enable_i(pair_en[i]),
      .stoppable_i(ctl_stoppable_i[i]), .stop_acc_i(stop_acc),
      .release_i(restart), .pd_park_i(pd_park_d),
      .stop_tri_i(ctl_stop_tri_i), .pd_tri_i(ctl_pd_tri_i), .drv_o(drv)
    );

    assign dif_t_o[i]    = drv.t;
    assign dif_c_o[i]    = drv.c;
    assign dif_t_en_o[i] = drv.t_en;
    assign dif_c_en_o[i] = drv.c_en;
  end
endmodule

// File: rtl/clkout_stop_seq_chk.sv
module clkout_stop_seq_chk #(
  parameter int N_PAIRS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [N_PAIRS-1:0] ctl_oe_i,
  input logic               ctl_pd_tri_i,
  input logic               pd_park_q,
  input logic [N_PAIRS-1:0] dif_t_o,
  input logic [N_PAIRS-1:0] dif_c_o,
  input logic [N_PAIRS-1:0] dif_t_en_o,
  input logic [N_PAIRS-1:0] dif_c_en_o
);
  for (genvar i = 0; i < N_PAIRS; i++) begin : g_a
    AST_OFF_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
      !ctl_oe_i[i] |=> (!dif_t_en_o[i] && !dif_c_en_o[i])); // R9

    AST_T_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (rst)
      !dif_t_en_o[i] |-> !dif_t_o[i]); // R4

    AST_C_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (rst)
      !dif_c_en_o[i] |-> !dif_c_o[i]); // R4

    AST_RUN_TOGGLES: assert property (@(posedge clk) disable iff (rst)
      (dif_t_en_o[i] && dif_c_en_o[i] && $past(dif_t_en_o[i] && dif_c_en_o[i]))
      |-> (dif_t_o[i] != $past(dif_t_o[i])) && (dif_c_o[i] != dif_t_o[i])); // R11

    AST_PD_TRI_PARK: assert property (@(posedge clk) disable iff (rst)
      (pd_park_q && $past(ctl_pd_tri_i)) |-> (!dif_t_en_o[i] && !dif_c_en_o[i])); // R6

    for (genvar j = i + 1; j < N_PAIRS; j++) begin : g_b
      AST_RUN_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
        (dif_t_en_o[i] && dif_c_en_o[i] && dif_t_en_o[j] && dif_c_en_o[j])
        |-> (dif_t_o[i] == dif_t_o[j])); // R5
    end
  end
endmodule

bind clkout_stop_seq clkout_stop_seq_chk #(.N_PAIRS(N_PAIRS)) u_chk (
  .clk(clk), .rst(rst), .ctl_oe_i(ctl_oe_i), .ctl_pd_tri_i(ctl_pd_tri_i),
  .pd_park_q(pd_park_q), .dif_t_o(dif_t_o), .dif_c_o(dif_c_o),
  .dif_t_en_o(dif_t_en_o), .dif_c_en_o(dif_c_en_o)
);

// File: tb/clkout_stop_seq_bench.sv
module clkout_stop_seq_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         stop_req = 1'b1;
  logic         pd_req = 1'b1;
  logic         strap = 1'b1;
  logic [N-1:0] oe_pin = '0;
  logic [N-1:0] ctl_oe = '1;
  logic [N-1:0] ctl_stoppable = 4'b0011;
  logic         stop_tri = 1'b0;
  logic         pd_tri = 1'b0;
  logic         req_inv = 1'b0;
  logic [N-1:0] dif_t, dif_c, dif_t_en, dif_c_en;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  typedef struct {
    int         at;
    int         idx;
    logic [3:0] v;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  clkout_stop_seq #(.N_PAIRS(N)) u_clkout_stop_seq (
    .clk(clk), .rst(rst), .stop_req_i(stop_req), .pd_req_i(pd_req),
    .oe_strap_i(strap), .oe_pin_i(oe_pin), .ctl_oe_i(ctl_oe),
    .ctl_stoppable_i(ctl_stoppable), .ctl_stop_tri_i(stop_tri),
    .ctl_pd_tri_i(pd_tri), .ctl_req_inv_i(req_inv),
    .dif_t_o(dif_t), .dif_c_o(dif_c), .dif_t_en_o(dif_t_en), .dif_c_en_o(dif_c_en)
  );

  // expected pattern {t, c, t_en, c_en}
  task automatic push(int at, int idx, logic [3:0] v, string tag);
    exp_t e;
    e.at = at; e.idx = idx; e.v = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic push_run(int at, int idx, string tag);
    logic t;
    t = logic'(at % 2);
    push(at, idx, {t, ~t, 2'b11}, tag);
  endtask

  function automatic int qual(int k);
    return k + (((k % 2) != 0) ? 5 : 6);
  endfunction

  function automatic logic lvl(bit active);
    return active ? req_inv : ~req_inv;
  endfunction

  task automatic goto(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin : mon
    exp_t       e;
    logic [3:0] a;
    if (!rst) begin
      while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
        e = sb_q.pop_front();
        a = {dif_t[e.idx], dif_c[e.idx], dif_t_en[e.idx], dif_c_en[e.idx]};
        total++;
        if (e.at != cyc || a !== e.v) begin
          bad++;
          $display("FAIL %s pair%0d cycle %0d: actual=%b expected=%b at cycle %0d",
                   e.tag, e.idx, cyc, a, e.v, e.at);
        end
      end
    end
  end

  task automatic do_stop(bit tri_mode);
    int k, q;
    stop_tri = tri_mode;
    repeat (3) @(negedge clk);
    k = cyc; stop_req = lvl(1); q = qual(k);
    push_run(q, 0, "R2");
    if (!tri_mode) begin
      push(q + 1, 0, 4'b1010, "R4");
      push_run(q + 1, 2, "R3");
      push(q + 3, 1, 4'b1010, "R3");
      push_run(q + 3, 2, "R3");
    end else begin
      push_run(q + 1, 0, "R4");
      push(q + 2, 0, 4'b0000, "R4");
      push(q + 4, 1, 4'b0000, "R3");
      push_run(q + 4, 3, "R3");
    end
    goto(q + 6);
    @(negedge clk);
    k = cyc; stop_req = lvl(0); q = qual(k);
    push(q + 6, 0, tri_mode ? 4'b0000 : 4'b1010, "R5");
    push_run(q + 7, 0, "R5");
    push_run(q + 7, 1, "R5");
    push_run(q + 7, 2, "R5");
    goto(q + 10);
  endtask

  task automatic do_pd(bit tri_mode);
    int k, q;
    logic [3:0] pv;
    pd_tri = tri_mode;
    pv = tri_mode ? 4'b0000 : 4'b1010;
    repeat (3) @(negedge clk);
    k = cyc; pd_req = lvl(1); q = qual(k);
    push_run(q, 2, "R6");
    for (int i = 0; i < N; i++) push(q + 1, i, pv, "R6");
    push(q + 4, 2, pv, "R6");
    goto(q + 6);
    @(negedge clk);
    k = cyc; pd_req = lvl(0); q = qual(k);
    push(q, 0, pv, "R6");
    push_run(q + 1, 0, "R6");
    push_run(q + 1, 2, "R6");
    goto(q + 4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    int k, q;
    // reset with strap=1: enable pins active-low
    repeat (3) @(negedge clk);
    check({dif_t, dif_c, dif_t_en, dif_c_en} === 16'h0, "R1 reset outputs",
          {dif_t, dif_c, dif_t_en, dif_c_en}, 16'h0);
    rst = 1'b0;
    for (int i = 0; i < N; i++) push_run(3, i, "R9 strap=1 pin=0");
    goto(4);
    strap = 1'b0; // R1: no effect after reset
    for (int i = 0; i < N; i++) push_run(7, i, "R1 strap ignored");
    goto(8);
    k = cyc; oe_pin[3] = 1'b1;
    push(k + 1, 3, 4'b0000, "R9 pin inactive");
    push_run(k + 1, 2, "R9");
    goto(k + 3);

    // second reset with strap=0: pins active-high
    rst = 1'b1; oe_pin = '1;
    repeat (3) @(negedge clk);
    check({dif_t, dif_c, dif_t_en, dif_c_en} === 16'h0, "R1 reset outputs",
          {dif_t, dif_c, dif_t_en, dif_c_en}, 16'h0);
    rst = 1'b0;
    for (int i = 0; i < N; i++) push_run(2, i, "R11");
    push_run(3, 0, "R11");
    goto(4);

    do_stop(1'b0);
    do_stop(1'b1);

    // single-cycle request pulse
    @(negedge clk);
    k = cyc; stop_req = lvl(1);
    @(negedge clk);
    stop_req = lvl(0);
    for (int d = 4; d <= 16; d += 3) push_run(k + d, 0, "R10");
    goto(k + 18);

    do_pd(1'b0);
    do_pd(1'b1);

    // both requests together: power-down wins
    stop_tri = 1'b1; pd_tri = 1'b0;
    repeat (2) @(negedge clk);
    k = cyc; stop_req = lvl(1); pd_req = lvl(1); q = qual(k);
    push(q + 1, 0, 4'b1010, "R7");
    push(q + 2, 0, 4'b1010, "R7");
    push(q + 2, 2, 4'b1010, "R7");
    goto(q + 6);
    @(negedge clk);
    k = cyc; stop_req = lvl(0); pd_req = lvl(0); q = qual(k);
    push(q + 1, 0, 4'b0000, "R7");
    push_run(q + 1, 2, "R7");
    push(q + 6, 1, 4'b0000, "R7");
    push_run(q + 7, 0, "R7");
    goto(q + 10);

    // inverted request polarity
    @(negedge clk);
    k = cyc; req_inv = 1'b1; stop_req = 1'b0; pd_req = 1'b0;
    for (int d = 3; d <= 15; d += 4) push_run(k + d, 0, "R8 idle");
    goto(k + 16);
    do_stop(1'b0);

    // control enable bit cleared
    @(negedge clk);
    k = cyc; ctl_oe[1] = 1'b0;
    push(k + 1, 1, 4'b0000, "R9 ctl bit");
    push_run(k + 1, 0, "R9");
    goto(k + 4);

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R11 pending: actual=%0d expected=0", sb_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule